// File: doc/BRIEF.md
# Frame Reference Monitor and Phase Slider

This block derives all of its timing from a single 16.384 MHz master clock. It counts out an internal 8 kHz frame of `FRAME_LEN` master cycles (2048 by default) and produces a one-cycle frame pulse. It also produces three bit clocks for the 8.192, 4.096 and 2.048 Mbit/s streams, each taken from the position inside the frame. Several 8 kHz reference inputs arrive asynchronously. Each one passes through its own synchronizer and its own activity watchdog, which raises a loss flag for that input alone.

A select input chooses which reference the generator follows. When the chosen reference is healthy and its frame edge does not line up with the generated frame, the generator does not jump. Instead it cuts one master cycle from each following frame, which is one eighth of a bit at 2.048 Mbit/s. It keeps doing this until the two frames agree to within one master cycle, and then it stops. While the chosen reference is flagged lost, the generator holds its phase and free-runs at the nominal frame length.

All pins are plain control and status signals. The block has no data stream, so no valid/ready handshake is involved.

Top module: `rfa_ref_aligner`

## Requirements
- R1: While reset is held, every loss flag reads 1 and the frame pulse is high, because the frame position is 0. The first frame after release lasts `FRAME_LEN` cycles.
- R2: When no correction is pending, the frame pulse is high for exactly one master cycle in every `FRAME_LEN` cycles.
- R3: In the cycle of the frame pulse all three bit clocks are low. After that, `bclk_8m`, `bclk_4m` and `bclk_2m` are bits 0, 1 and 2 of the frame position: at position 1 only the 8M clock is high, at position 2 only the 4M clock, and at position 4 only the 2M clock.
- R4: A reference's loss flag rises about `LOSS_FRAMES*FRAME_LEN` cycles (3 frames) after its last rising edge, counted from the edge once it has been synchronized. Until then it stays low.
- R5: A lost flag clears on the second of two rising edges that are `FRAME_LEN`±1 cycles apart. Edges at any other spacing leave the flag set.
- R6: Each reference has its own loss flag. Activity or silence on one input does not change the flag of another input.
- R7: While the chosen reference is healthy and misaligned, each frame is shortened by exactly one cycle, to `FRAME_LEN-1`. No frame is ever shorter than that.
- R8: Sliding stops once the reference edge falls within ±1 master cycle of the generated frame start. The frame period then returns to `FRAME_LEN`.
- R9: While the chosen reference is flagged lost, no frame is shortened and the period stays at `FRAME_LEN`.
- R10: `ref_sel` picks which reference index is followed. After a change of selection, the frame converges to the newly chosen input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NREF | Asynchronous 8 kHz reference inputs |
| ref_sel | input | SELW | Index of the reference to follow |
| frame_pulse | output | 1 | One-cycle generated frame start |
| bclk_8m | output | 1 | 8.192 Mbit/s bit clock |
| bclk_4m | output | 1 | 4.096 Mbit/s bit clock |
| bclk_2m | output | 1 | 2.048 Mbit/s bit clock |
| ref_lost | output | NREF | Per-reference loss flags |

## Verification
The bench starts from a large phase error and tracks every frame period. A design that jumped instead of sliding, or that removed more than one cycle per frame, would show a period below `FRAME_LEN-1`. A design that kept sliding after alignment would never return to the nominal period. A reference kept at the wrong spacing tests recovery: a monitor that cleared its flag on any edge would let the generator follow that input, and the frames would shorten during holdover. The bench also times the loss threshold from both sides, and it checks that the flags of the other inputs stay put.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  // spacing tolerance for a recovering reference, in master cycles
  localparam int unsigned SPACING_TOL = 1;
  // phase error accepted as aligned, in master cycles
  localparam int unsigned ALIGN_TOL = 1;

  function automatic logic within_tol(input int unsigned val,
                                      input int unsigned target,
                                      input int unsigned tol);
    return (val + tol >= target) && (val <= target + tol);
  endfunction
endpackage

// File: rtl/rfa_ref_mon.sv
module rfa_ref_mon #(
  parameter int unsigned FRAME_LEN   = 2048,
  parameter int unsigned LOSS_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_edge,
  output logic ref_lost
);
  import rfa_pkg::*;

  localparam int unsigned LIMIT = FRAME_LEN * LOSS_FRAMES;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] since_q;
  logic          lost_q;
  logic [31:0]   gap;

  assign ref_edge = sync_q[1] & ~sync_q[2];
  assign gap      = 32'(since_q) + 32'd1;
  assign ref_lost = lost_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      since_q <= CW'(LIMIT);
      lost_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[1:0], ref_in};
      if (ref_edge) begin
        since_q <= '0;
        if (within_tol(gap, FRAME_LEN, SPACING_TOL)) lost_q <= 1'b0;
      end else begin
        if (since_q != CW'(LIMIT)) since_q <= since_q + CW'(1);
        if (gap >= LIMIT) lost_q <= 1'b1;
      end
    end
  end

  AST_LOSS_AFTER_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> ($past(since_q) == CW'(LIMIT - 1))); // R4
  AST_CLEAR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_q) |-> $past(ref_edge)); // R5
endmodule

// File: rtl/rfa_frame_gen.sv
module rfa_frame_gen #(
  parameter int unsigned FRAME_LEN = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic ref_lost,
  output logic frame_pulse,
  output logic bclk_8m,
  output logic bclk_4m,
  output logic bclk_2m
);
  import rfa_pkg::*;

  localparam int unsigned CW = $clog2(FRAME_LEN);

  logic [CW-1:0] pos_q;
  logic          slide_q;
  logic          aligned;
  logic          wrap;
  logic          shorten;

  // phase error is the frame position seen at the reference edge
  assign aligned = (pos_q <= CW'(ALIGN_TOL)) || (pos_q >= CW'(FRAME_LEN - ALIGN_TOL));
  assign shorten = slide_q && !ref_lost;
  assign wrap    = shorten ? (pos_q == CW'(FRAME_LEN - 2)) : (pos_q == CW'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      slide_q <= 1'b0;
    end else begin
      pos_q <= wrap ? '0 : pos_q + CW'(1);
      if (ref_lost)      slide_q <= 1'b0;
      else if (ref_edge) slide_q <= !aligned;
      else if (wrap)     slide_q <= 1'b0;
    end
  end

  assign frame_pulse = (pos_q == '0);
  assign bclk_8m     = pos_q[0];
  assign bclk_4m     = pos_q[1];
  assign bclk_2m     = pos_q[2];

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse); // R2
  AST_POS_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0) |-> (pos_q == $past(pos_q) + CW'(1))); // R7
  AST_NO_SLIDE_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos_q == '0) && ($past(pos_q) == CW'(FRAME_LEN - 2))) |-> !$past(ref_lost)); // R9
endmodule

// File: rtl/rfa_ref_aligner.sv
module rfa_ref_aligner #(
  parameter int unsigned NREF        = 4,
  parameter int unsigned FRAME_LEN   = 2048,
  parameter int unsigned LOSS_FRAMES = 3,
  parameter int unsigned SELW        = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREF-1:0] ref_in,
  input  logic [SELW-1:0] ref_sel,
  output logic            frame_pulse,
  output logic            bclk_8m,
  output logic            bclk_4m,
  output logic            bclk_2m,
  output logic [NREF-1:0] ref_lost
);
  logic [NREF-1:0] edges;
  logic            sel_edge;
  logic            sel_lost;

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    rfa_ref_mon #(.FRAME_LEN(FRAME_LEN), .LOSS_FRAMES(LOSS_FRAMES)) i_mon (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in[g]),
      .ref_edge(edges[g]), .ref_lost(ref_lost[g]));
  end

  // an index outside the populated range reads as a lost input
  always_comb begin
    sel_edge = 1'b0;
    sel_lost = 1'b1;
    for (int i = 0; i < NREF; i++) begin
      if (int'(ref_sel) == i) begin
        sel_edge = edges[i];
        sel_lost = ref_lost[i];
      end
    end
  end

  rfa_frame_gen #(.FRAME_LEN(FRAME_LEN)) i_gen (
    .clk(clk), .rst_n(rst_n), .ref_edge(sel_edge), .ref_lost(sel_lost),
    .frame_pulse(frame_pulse), .bclk_8m(bclk_8m), .bclk_4m(bclk_4m),
    .bclk_2m(bclk_2m));

  AST_SEL_EDGE_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_lost) && $stable(ref_sel) |-> $past(sel_edge)); // R10
endmodule

// File: tb/test_rfa_ref_aligner.sv
module test_rfa_ref_aligner;
  localparam int F = 64;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] ref_in = '0;
  logic [1:0] ref_sel = '0;
  logic frame_pulse, bclk_8m, bclk_4m, bclk_2m;
  logic [NR-1:0] ref_lost;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;
  bit en [NR];
  int per [NR];
  int ph [NR];
  int last_drv [NR];
  int last_pulse = 0, win_min = 1 << 30, win_max = 0;

  always #5 clk = ~clk;

  rfa_ref_aligner #(.NREF(NR), .FRAME_LEN(F), .LOSS_FRAMES(3)) i_rfa_ref_aligner (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_sel(ref_sel),
    .frame_pulse(frame_pulse), .bclk_8m(bclk_8m), .bclk_4m(bclk_4m),
    .bclk_2m(bclk_2m), .ref_lost(ref_lost));

  // sample at the falling edge, then drive the references for the next cycle
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && frame_pulse) begin
      int p;
      p = cyc - last_pulse;
      last_pulse = cyc;
      if (p < win_min) win_min = p;
      if (p > win_max) win_max = p;
    end
    for (int i = 0; i < NR; i++) begin
      bit hi;
      hi = en[i] && ((((cyc - ph[i]) % per[i]) + per[i]) % per[i] == 0);
      ref_in[i] <= hi;
      if (hi) last_drv[i] = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic open_window();
    @(posedge clk); #2;
    while (!frame_pulse) begin @(posedge clk); #2; end
    win_min = 1 << 30;
    win_max = 0;
  endtask

  function automatic int offset(input int r);
    return (((last_pulse - last_drv[r]) % F) + F) % F;
  endfunction

  task automatic t_reset();
    cycles(3);
    chk(ref_lost == '1, "R1", ref_lost, 4'hF);
    chk(frame_pulse == 1'b1, "R1", frame_pulse, 1);
    @(negedge clk); rst_n = 1'b1;
    open_window();
    cycles(F * 2 + 2);
    chk(win_min == F && win_max == F, "R2", win_min, F);
  endtask

  task automatic t_recover();
    ph[0] = cyc + 5; per[0] = F; en[0] = 1;
    cycles(F / 2 + 10);
    chk(ref_lost[0] == 1'b1, "R5", ref_lost[0], 1);
    cycles(F);
    chk(ref_lost[0] == 1'b0, "R5", ref_lost[0], 0);
    chk(ref_lost[3:1] == 3'b111, "R6", ref_lost[3:1], 7);
  endtask

  task automatic t_align();
    // select ref0 well out of phase: the frame slides one cycle per frame
    ref_sel = 2'd0;
    open_window();
    cycles(F * 20);
    chk(win_min == F - 1, "R7", win_min, F - 1);
    cycles(F * 70);
    open_window();
    cycles(F * 8);
    chk(win_min == F && win_max == F, "R8", win_max, F);
    chk(offset(0) >= 1 && offset(0) <= 3, "R8", offset(0), 2);
  endtask

  task automatic t_bitclk();
    @(posedge clk); #2;
    while (!frame_pulse) begin @(posedge clk); #2; end
    chk({bclk_8m, bclk_4m, bclk_2m} == 3'b000, "R3", {bclk_8m, bclk_4m, bclk_2m}, 0);
    cycles(1);
    chk({bclk_8m, bclk_4m, bclk_2m} == 3'b100, "R3", {bclk_8m, bclk_4m, bclk_2m}, 4);
    cycles(1);
    chk({bclk_8m, bclk_4m, bclk_2m} == 3'b010, "R3", {bclk_8m, bclk_4m, bclk_2m}, 2);
    cycles(2);
    chk({bclk_8m, bclk_4m, bclk_2m} == 3'b001, "R3", {bclk_8m, bclk_4m, bclk_2m}, 1);
  endtask

  task automatic t_holdover();
    // ref1 runs at a wrong spacing: it must stay lost and never steer the frame
    ph[1] = cyc + 17; per[1] = F + 5; en[1] = 1;
    ref_sel = 2'd1;
    open_window();
    cycles(F * 10);
    chk(ref_lost[1] == 1'b1, "R5", ref_lost[1], 1);
    chk(win_min == F && win_max == F, "R9", win_min, F);
    en[1] = 0;
  endtask

  task automatic t_select();
    ph[2] = last_drv[0] + 23; per[2] = F; en[2] = 1;
    cycles(F * 3);
    chk(ref_lost[2] == 1'b0, "R6", ref_lost[2], 0);
    ref_sel = 2'd2;
    cycles(F * 75);
    open_window();
    cycles(F * 6);
    chk(offset(2) >= 1 && offset(2) <= 3, "R10", offset(2), 2);
    chk(win_min == F && win_max == F, "R10", win_min, F);
  endtask

  task automatic t_loss();
    int t0;
    en[2] = 0;
    cycles(2);
    t0 = last_drv[2];
    while (cyc < t0 + 3 * F - 6) cycles(1);
    chk(ref_lost[2] == 1'b0, "R4", ref_lost[2], 0);
    while (cyc < t0 + 3 * F + 8) cycles(1);
    chk(ref_lost[2] == 1'b1, "R4", ref_lost[2], 1);
    chk(ref_lost[0] == 1'b0, "R6", ref_lost[0], 0);
    // ref2 is still selected and lost: the phase is held, ref0 runs off-phase
    en[0] = 0;
    en[2] = 0;
    en[0] = 1; ph[0] = last_drv[0] + 30;
    open_window();
    cycles(F * 8);
    chk(win_min == F && win_max == F, "R9", win_min, F);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin
      en[i] = 0; per[i] = F; ph[i] = 0; last_drv[i] = 0;
    end
    t_reset();
    t_recover();
    t_align();
    t_bitclk();
    t_holdover();
    t_select();
    t_loss();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule